// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address into a translation-cache entry after the cache has missed. The core raises a one-cycle walk request with the virtual address, the table base and the extended-page option. The walker then fetches a first-level descriptor over a single-outstanding 32-bit read port. If that descriptor points to a coarse or fine page table, it fetches a second-level descriptor as well.

A successful walk ends with a one-cycle fill toward the cache. The fill carries the masked virtual tag, the masked physical word, the permission bits, the domain and the mapping kind. A walk that hits an invalid descriptor ends with a one-cycle done that carries a fault code and no fill. Permission checking and cache storage are left to the neighbouring blocks.

Top module: `xlat_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, walkDone, fillValid and memReq are low.
- R2: The first read goes to address {tableBase[31:14], walkVa[31:20], 2'b00}.
- R3: A first-level descriptor with low bits 0 ends the walk with faultCode 1 (section translation fault), no fill and a single read.
- R4: A first-level descriptor with low bits 2 is a section. The walk makes no second read and fills fillKind 0, fillPhys = desc & 0xFFF00000, fillVa = va & 0xFFF00000 and fillPerm = desc[11:0] & 0xC0C.
- R5: First-level low bits 1 select a coarse table, with the second read at {desc[31:10], va[19:12], 2'b00}. Low bits 3 select a fine table, with the second read at {desc[31:12], va[19:10], 2'b00}.
- R6: fillDomain on every fill, and faultDomain on a page fault, equal first-level descriptor bits [8:5]. faultDomain is 0 on a section translation fault.
- R7: A second-level descriptor with low bits 0 ends the walk with faultCode 2 (page translation fault) and no fill.
- R8: Second-level low bits 1 fill fillKind 1 (large) with mask 0xFFFF0000. Low bits 2 fill fillKind 2 (small) with mask 0xFFFFF000. Every page fill has fillPerm = desc2[11:0] & 0xFFC and fillPhys = desc2 & mask.
- R9: Second-level low bits 3 under a fine table fill fillKind 3 (tiny) with mask 0xFFFFFC00. Under a coarse table they fill fillKind 4 (extended small, mask 0xFFFFF000) when extSmallEn was high at the request, and give faultCode 2 otherwise.
- R10: memReq is a one-cycle pulse, and only one read is outstanding at a time. memValid is ignored unless a read is outstanding. walkDone is a one-cycle pulse, and fillValid is high only with walkDone and faultCode 0.
- R11: walkReq is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walkReq | input | 1 | Start a walk (one cycle, taken only when idle) |
| walkVa | input | 32 | Virtual address to translate |
| tableBase | input | 32 | First-level table base register |
| extSmallEn | input | 1 | Treat coarse type-3 entries as extended small pages |
| memReq | output | 1 | Read request pulse |
| memAddr | output | 32 | Read word address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| walkDone | output | 1 | Walk finished (one cycle) |
| faultCode | output | 2 | 0 none, 1 section translation, 2 page translation |
| faultDomain | output | 4 | Domain reported with a page fault |
| fillValid | output | 1 | Write the entry into the translation cache |
| fillVa | output | 32 | Masked virtual tag |
| fillPhys | output | 32 | Masked physical word |
| fillPerm | output | 12 | Permission bits |
| fillDomain | output | 4 | Domain |
| fillKind | output | 3 | 0 section, 1 large, 2 small, 3 tiny, 4 extended small |

## Verification
The hardest cases to reach from the ports are stray memValid pulses and repeated walkReq pulses that arrive while a read is only requested or a walk is half done. Junk data on such a pulse must change nothing. The bench reaches these cases by driving a junk response in the same cycle as each memReq pulse, and by raising walkReq with a different address while the first-level read is outstanding. It then checks both read addresses and the final fill against values computed from the original request. Random descriptors with random response latency cover all type combinations. Directed walks pin down the coarse type-3 case with the extension option both on and off.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W    = 32;
  localparam int PERM_W  = 12;
  localparam int DOM_W   = 4;
  localparam int DOM_LSB = 5;
  localparam int KIND_W  = 3;
  localparam int FLT_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walkState_t;

  typedef enum logic [KIND_W-1:0] {
    MAP_SECTION = 3'd0, MAP_LARGE = 3'd1, MAP_SMALL = 3'd2,
    MAP_TINY = 3'd3, MAP_XSMALL = 3'd4
  } mapKind_t;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE = 2'd0, FLT_SECTION = 2'd1, FLT_PAGE = 2'd2
  } walkFault_t;

  typedef struct packed {
    logic capReq;
    logic capL1;
    logic capL2;
    logic useL2Addr;
  } walkStrobe_t;

  function automatic logic [VA_W-1:0] kindMask(input mapKind_t k);
    case (k)
      MAP_SECTION: kindMask = 32'hFFF0_0000;
      MAP_LARGE:   kindMask = 32'hFFFF_0000;
      MAP_TINY:    kindMask = 32'hFFFF_FC00;
      default:     kindMask = 32'hFFFF_F000;
    endcase
  endfunction
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walkReq,
  input  logic        extSmallEn,
  input  logic        memValid,
  input  logic [1:0]  memType,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        walkDone,
  output logic        fillValid,
  output mapKind_t    kindQ,
  output walkFault_t  faultQ
);
  walkState_t stateQ, stateD;
  mapKind_t   kindD;
  walkFault_t faultD;
  logic       fineQ, fineD;
  logic       extQ, extD;

  always_comb begin
    stateD = stateQ;
    kindD  = kindQ;
    faultD = faultQ;
    fineD  = fineQ;
    extD   = extQ;
    case (stateQ)
      ST_IDLE: if (walkReq) begin
        extD   = extSmallEn;
        faultD = FLT_NONE;
        kindD  = MAP_SECTION;
        stateD = ST_L1_REQ;
      end
      ST_L1_REQ: stateD = ST_L1_WAIT;
      ST_L1_WAIT: if (memValid) begin
        case (memType)
          2'd0: begin faultD = FLT_SECTION; stateD = ST_DONE; end
          2'd2: begin kindD = MAP_SECTION; stateD = ST_DONE; end
          2'd1: begin fineD = 1'b0; stateD = ST_L2_REQ; end
          default: begin fineD = 1'b1; stateD = ST_L2_REQ; end
        endcase
      end
      ST_L2_REQ: stateD = ST_L2_WAIT;
      ST_L2_WAIT: if (memValid) begin
        stateD = ST_DONE;
        case (memType)
          2'd0: faultD = FLT_PAGE;
          2'd1: kindD = MAP_LARGE;
          2'd2: kindD = MAP_SMALL;
          default: begin
            if (fineQ)     kindD = MAP_TINY;
            else if (extQ) kindD = MAP_XSMALL;
            else           faultD = FLT_PAGE;
          end
        endcase
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      kindQ  <= MAP_SECTION;
      faultQ <= FLT_NONE;
      fineQ  <= 1'b0;
      extQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
      faultQ <= faultD;
      fineQ  <= fineD;
      extQ   <= extD;
    end
  end

  always_comb begin
    strobe.capReq    = (stateQ == ST_IDLE) && walkReq;
    strobe.capL1     = (stateQ == ST_L1_WAIT) && memValid;
    strobe.capL2     = (stateQ == ST_L2_WAIT) && memValid;
    strobe.useL2Addr = (stateQ == ST_L2_REQ);
  end

  assign memReq    = (stateQ == ST_L1_REQ) || (stateQ == ST_L2_REQ);
  assign walkDone  = (stateQ == ST_DONE);
  assign fillValid = walkDone && (faultQ == FLT_NONE);
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   walkVa,
  input  logic [VA_W-1:14]  baseHi,
  input  logic [VA_W-1:0]   memData,
  input  mapKind_t          kind,
  input  walkFault_t        fault,
  output logic [VA_W-1:0]   memAddr,
  output logic [VA_W-1:0]   fillVa,
  output logic [VA_W-1:0]   fillPhys,
  output logic [PERM_W-1:0] fillPerm,
  output logic [DOM_W-1:0]  fillDomain,
  output logic [DOM_W-1:0]  faultDomain
);
  localparam logic [PERM_W-1:0] SECT_PERM_MASK = 12'hC0C;
  localparam logic [PERM_W-1:0] PAGE_PERM_MASK = 12'hFFC;

  logic [VA_W-1:0]  vaQ, l1Q, l2Q;
  logic [VA_W-1:14] baseQ;
  logic [VA_W-1:0]  l1Addr, l2Addr, mask, srcDesc;
  logic             fineTbl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaQ   <= '0;
      baseQ <= '0;
      l1Q   <= '0;
      l2Q   <= '0;
    end else begin
      if (strobe.capReq) begin
        vaQ   <= walkVa;
        baseQ <= baseHi;
      end
      if (strobe.capL1) l1Q <= memData;
      if (strobe.capL2) l2Q <= memData;
    end
  end

  assign fineTbl = (l1Q[1:0] == 2'd3);
  assign l1Addr  = {baseQ, vaQ[31:20], 2'b00};
  assign l2Addr  = fineTbl ? {l1Q[31:12], vaQ[19:10], 2'b00}
                           : {l1Q[31:10], vaQ[19:12], 2'b00};
  assign memAddr = strobe.useL2Addr ? l2Addr : l1Addr;

  assign mask     = kindMask(kind);
  assign srcDesc  = (kind == MAP_SECTION) ? l1Q : l2Q;
  assign fillVa   = vaQ & mask;
  assign fillPhys = srcDesc & mask;
  assign fillPerm = (kind == MAP_SECTION) ? (l1Q[PERM_W-1:0] & SECT_PERM_MASK)
                                          : (l2Q[PERM_W-1:0] & PAGE_PERM_MASK);
  assign fillDomain  = l1Q[DOM_LSB +: DOM_W];
  assign faultDomain = (fault == FLT_PAGE) ? l1Q[DOM_LSB +: DOM_W] : '0;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walkReq,
  input  logic [31:0] walkVa,
  input  logic [31:0] tableBase,
  input  logic        extSmallEn,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memValid,
  input  logic [31:0] memData,
  output logic        walkDone,
  output logic [1:0]  faultCode,
  output logic [3:0]  faultDomain,
  output logic        fillValid,
  output logic [31:0] fillVa,
  output logic [31:0] fillPhys,
  output logic [11:0] fillPerm,
  output logic [3:0]  fillDomain,
  output logic [2:0]  fillKind
);
  walkStrobe_t strobe;
  mapKind_t    kindQ;
  walkFault_t  faultQ;

  walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .walkReq(walkReq), .extSmallEn(extSmallEn),
    .memValid(memValid), .memType(memData[1:0]), .strobe(strobe),
    .memReq(memReq), .walkDone(walkDone), .fillValid(fillValid),
    .kindQ(kindQ), .faultQ(faultQ)
  );

  walk_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .walkVa(walkVa),
    .baseHi(tableBase[31:14]), .memData(memData), .kind(kindQ), .fault(faultQ),
    .memAddr(memAddr), .fillVa(fillVa), .fillPhys(fillPhys),
    .fillPerm(fillPerm), .fillDomain(fillDomain), .faultDomain(faultDomain)
  );

  assign faultCode = faultQ;
  assign fillKind  = kindQ;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        walkDone,
  input logic [1:0]  faultCode,
  input logic        fillValid,
  input logic [31:0] fillPhys,
  input logic [11:0] fillPerm,
  input logic [2:0]  fillKind
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |=> !memReq); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walkDone |=> !walkDone); // R10
  AST_FILL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |-> walkDone && faultCode == 2'd0); // R10
  AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    walkDone && faultCode != 2'd0 |-> !fillValid); // R7
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> memAddr[1:0] == 2'b00); // R2
  AST_SECT_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid && fillKind == 3'd0 |-> (fillPerm & ~12'hC0C) == 12'h0); // R4
  AST_SECT_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid && fillKind == 3'd0 |-> fillPhys[19:0] == 20'h0); // R4
  AST_PAGE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid && fillKind != 3'd0 |-> fillPerm[1:0] == 2'b00); // R8
  AST_KIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |-> fillKind <= 3'd4); // R9
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .memReq(memReq), .memAddr(memAddr),
  .walkDone(walkDone), .faultCode(faultCode), .fillValid(fillValid),
  .fillPhys(fillPhys), .fillPerm(fillPerm), .fillKind(fillKind)
);

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic walkReq = 1'b0, extSmallEn = 1'b0, memValid = 1'b0;
  logic [31:0] walkVa = '0, tableBase = '0, memData = '0;
  logic memReq, walkDone, fillValid;
  logic [31:0] memAddr, fillVa, fillPhys;
  logic [1:0] faultCode;
  logic [3:0] faultDomain, fillDomain;
  logic [11:0] fillPerm;
  logic [2:0] fillKind;

  int total = 0, bad = 0, reqCount = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u0 (
    .clk(clk), .rst_n(rst_n), .walkReq(walkReq), .walkVa(walkVa),
    .tableBase(tableBase), .extSmallEn(extSmallEn), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .walkDone(walkDone), .faultCode(faultCode), .faultDomain(faultDomain),
    .fillValid(fillValid), .fillVa(fillVa), .fillPhys(fillPhys),
    .fillPerm(fillPerm), .fillDomain(fillDomain), .fillKind(fillKind)
  );

  always @(posedge clk) if (rst_n && memReq) reqCount++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input int k);
    case (k)
      0: return 32'hFFF0_0000;
      1: return 32'hFFFF_0000;
      3: return 32'hFFFF_FC00;
      default: return 32'hFFFF_F000;
    endcase
  endfunction

  task automatic waitReq(output bit got);
    got = 0;
    for (int i = 0; i < 50; i++) begin
      if (memReq) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic respond(input logic [31:0] d, input bit junk, input int lat,
                         input bit busyReq, input logic [31:0] otherVa);
    // called at the negedge where memReq is high
    if (junk) begin memValid = 1'b1; memData = ~d; end
    @(negedge clk);
    memValid = 1'b0;
    if (busyReq) begin walkReq = 1'b1; walkVa = otherVa; end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      walkReq = 1'b0;
    end
    walkReq = 1'b0;
    memValid = 1'b1; memData = d;
    @(negedge clk);
    memValid = 1'b0; memData = $urandom;
  endtask

  task automatic runWalk(input logic [31:0] va, input logic [31:0] base,
                         input logic [31:0] d1, input logic [31:0] d2,
                         input bit ext, input bit junk);
    int startReq, expReads, expFault, expKind;
    logic [31:0] expL1, expL2, m, src;
    logic [11:0] expPerm;
    bit got, fine;
    expL1 = {base[31:14], va[31:20], 2'b00};
    fine = (d1[1:0] == 2'd3);
    expL2 = fine ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
    expReads = 2; expFault = 0; expKind = 0;
    case (d1[1:0])
      2'd0: begin expReads = 1; expFault = 1; end
      2'd2: begin expReads = 1; expKind = 0; end
      default: case (d2[1:0])
        2'd0: expFault = 2;
        2'd1: expKind = 1;
        2'd2: expKind = 2;
        default: if (fine) expKind = 3; else if (ext) expKind = 4; else expFault = 2;
      endcase
    endcase
    m = maskOf(expKind);
    src = (expKind == 0) ? d1 : d2;
    expPerm = (expKind == 0) ? (d1[11:0] & 12'hC0C) : (d2[11:0] & 12'hFFC);

    @(negedge clk);
    startReq = reqCount;
    walkReq = 1'b1; walkVa = va; tableBase = base; extSmallEn = ext;
    @(negedge clk);
    walkReq = 1'b0; extSmallEn = ~ext; tableBase = ~base;
    walkVa = $urandom;
    waitReq(got);
    check(got && memAddr == expL1, "R2 first read address", memAddr, expL1);
    respond(d1, junk, $urandom_range(0, 3), junk, ~va);
    if (expReads == 2) begin
      waitReq(got);
      check(got && memAddr == expL2, "R5 second read address", memAddr, expL2);
      respond(d2, junk, $urandom_range(0, 3), 1'b0, 32'h0);
    end
    for (int i = 0; i < 50 && !walkDone; i++) @(negedge clk);
    check(walkDone == 1'b1, "R10 walk completes", {31'b0, walkDone}, 32'h1);
    check(reqCount - startReq == expReads, "R4 R3 read count",
          reqCount - startReq, expReads);
    check(faultCode == expFault[1:0], "R3 R7 R9 fault code", {30'b0, faultCode}, expFault);
    if (expFault == 0) begin
      check(fillValid == 1'b1, "R10 fill on success", {31'b0, fillValid}, 32'h1);
      check(fillKind == expKind[2:0], "R4 R8 R9 fill kind", {29'b0, fillKind}, expKind);
      check(fillPhys == (src & m), "R4 R8 fill physical", fillPhys, src & m);
      check(fillVa == (va & m), "R11 R8 fill virtual tag", fillVa, va & m);
      check(fillPerm == expPerm, "R4 R8 fill permissions", {20'b0, fillPerm}, {20'b0, expPerm});
      check(fillDomain == d1[8:5], "R6 fill domain", {28'b0, fillDomain}, {28'b0, d1[8:5]});
    end else begin
      check(fillValid == 1'b0, "R7 no fill on fault", {31'b0, fillValid}, 32'h0);
      check(faultDomain == ((expFault == 2) ? d1[8:5] : 4'h0), "R6 fault domain",
            {28'b0, faultDomain}, (expFault == 2) ? {28'b0, d1[8:5]} : 32'h0);
    end
    @(negedge clk);
    check(!walkDone && !fillValid && !memReq, "R10 done is one cycle",
          {29'b0, walkDone, fillValid, memReq}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, base, d1, d2;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(!walkDone && !fillValid && !memReq, "R1 reset outputs",
          {29'b0, walkDone, fillValid, memReq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!walkDone && !fillValid && !memReq, "R1 after reset",
          {29'b0, walkDone, fillValid, memReq}, 32'h0);

    // R10: stray valid while idle is ignored
    memValid = 1'b1; memData = 32'hFFFF_FFFE;
    @(negedge clk); @(negedge clk);
    memValid = 1'b0;
    check(!walkDone && !memReq, "R10 idle valid ignored", {30'b0, walkDone, memReq}, 32'h0);

    // directed corners
    runWalk(32'h1234_5678, 32'hABCD_C000, 32'h0000_01E0, 32'h0, 0, 0); // R3
    runWalk(32'h8765_4321, 32'h0001_4000, 32'h4560_0DEE, 32'h0, 0, 1); // R4
    runWalk(32'hC0DE_F123, 32'h0, 32'h1111_2561, 32'h5555_6FF0, 0, 1); // R7 coarse
    runWalk(32'hC0DE_F123, 32'h0, 32'h1111_2561, 32'h5555_6FF1, 0, 0); // R8 large
    runWalk(32'hC0DE_F123, 32'h0, 32'h1111_2561, 32'h5555_6FF2, 0, 0); // R8 small
    runWalk(32'hC0DE_F123, 32'h0, 32'h1111_2563, 32'h5555_6FF3, 0, 0); // R9 tiny
    runWalk(32'hC0DE_F123, 32'h0, 32'h1111_2561, 32'h5555_6FF3, 1, 1); // R9 ext on
    runWalk(32'hC0DE_F123, 32'h0, 32'h1111_2561, 32'h5555_6FF3, 0, 1); // R9 ext off

    for (int n = 0; n < 60; n++) begin
      va = $urandom; base = $urandom; d1 = $urandom; d2 = $urandom;
      runWalk(va, base, d1, d2, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule